// File: doc/BRIEF.md
# Two-Level Reset Sequencing Controller

This block produces the system reset from two supply-monitor comparator flags. The first flag (`por_low_i`) means the supply has fallen below the power-on threshold. The second flag (`bor_low_i`) means it has fallen below a programmable brownout threshold. The block keeps the active-low system reset asserted while either condition holds.

On release, the block reports which class of reset just ended. Register banks elsewhere use this to choose between their power-on defaults and their brownout defaults.

- **Power-on recovery.** Reset is released only after a parameterised power-up delay runs to its end.
- **Brownout recovery.** Reset is released as soon as the synchronised brownout flag clears, with no delay. The 2-bit brownout threshold-select field keeps its value through a brownout. Only a power-on event clears it.

The block also presents a fixed restart address for the processor. The threshold-select field can be written by software through a one-cycle write strobe, and only while the system is out of reset.

The power-on flag acts as the controller's own synchronous, active-high reset. The brownout flag passes through a two-flop synchroniser before it is used.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `por_low_i` is high, `rst_n_o` is 0, `bor_thr_o` is 00b, `reset_class_o` is 0 (power-on class), and both event pulses are 0.
- R2: With `bor_low_i` low, `rst_n_o` rises exactly PWRUP_CYCLES+2 rising clock edges after the first edge at which `por_low_i` is low. `por_event_o` is 1 for exactly that one cycle.
- R3: While `bor_low_i` is high during a power-up wait, `rst_n_o` stays 0 and the delay restarts. Release then follows exactly PWRUP_CYCLES+2 edges after the first edge at which `bor_low_i` is sampled low.
- R4: From the running state, `rst_n_o` falls on the third rising edge at which `bor_low_i` is sampled high, and is still 1 after the second. `reset_class_o` becomes 1 (brownout class).
- R5: `rst_n_o` stays 0 for as long as `bor_low_i` stays high.
- R6: A brownout recovery releases `rst_n_o` on the third rising edge at which `bor_low_i` is sampled low, with no power-up delay. `bor_event_o` is 1 for exactly that cycle, and `por_event_o` stays 0.
- R7: `bor_thr_o` keeps its value through a brownout that does not reach the power-on threshold.
- R8: A power-on event clears `bor_thr_o` to 00b.
- R9: When `wr_en_i` is 1 at a rising edge while `rst_n_o` is 1, `bor_thr_o` takes `wr_thr_i` from the next cycle. While `rst_n_o` is 0, or when `wr_en_i` is 0, the field is unchanged.
- R10: `restart_addr_o` equals 16'h8000 with default parameters.
- R11: `por_event_o` and `bor_event_o` are never 1 together. Every rise of `rst_n_o` coincides with exactly one of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_low_i | input | 1 | Supply below power-on threshold; synchronous active-high reset of the controller |
| bor_low_i | input | 1 | Supply below brownout threshold (asynchronous comparator output) |
| wr_en_i | input | 1 | Write strobe for the threshold-select field |
| wr_thr_i | input | 2 | Data for the threshold-select field |
| rst_n_o | output | 1 | Active-low system reset |
| por_event_o | output | 1 | One-cycle pulse at release after a power-on reset |
| bor_event_o | output | 1 | One-cycle pulse at release after a brownout reset |
| reset_class_o | output | 1 | Class of the latest reset: 0 power-on, 1 brownout |
| bor_thr_o | output | 2 | Brownout threshold-select field |
| restart_addr_o | output | 16 | Address at which execution restarts after release |

## Verification
The assertions check these properties on every cycle:
- the two event pulses are mutually exclusive;
- each event pulse coincides with a rise of the reset output;
- the threshold field is frozen while reset is held;
- a brownout release reports the brownout class.

Only the bench scenarios can show the exact release latencies of both recovery paths. The same holds for the restart of the power-up delay under a concurrent brownout, the retention of the field through a brownout, and its clearing by a power-on event.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

    localparam int THR_W = 2;

    typedef enum logic [1:0] {
        ST_PWRUP    = 2'd0,
        ST_BOR_HOLD = 2'd1,
        ST_RUN      = 2'd2
    } seq_st_e;

    typedef enum logic {
        RCLS_POWERON  = 1'b0,
        RCLS_BROWNOUT = 1'b1
    } rcls_e;

    typedef struct packed {
        logic por_evt;
        logic bor_evt;
    } evt_t;

    function automatic logic is_running(seq_st_e st);
        return st == ST_RUN;
    endfunction

    function automatic evt_t release_kind(seq_st_e cur, seq_st_e nxt);
        evt_t e;
        e.por_evt = (cur == ST_PWRUP)    && (nxt == ST_RUN);
        e.bor_evt = (cur == ST_BOR_HOLD) && (nxt == ST_RUN);
        return e;
    endfunction

endpackage

// File: rtl/rsc_sync.sv
module rsc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= RST_VAL;
                    else     chain[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= RST_VAL;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/rsc_pwrup_timer.sv
module rsc_pwrup_timer #(
    parameter int CYCLES = 65536
) (
    input  logic clk,
    input  logic clr_i,
    output logic done_o
);
    localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (clr_i)          cnt <= '0;
        else if (cnt != LAST) cnt <= cnt + 1'b1;
    end

    assign done_o = (cnt == LAST);
endmodule

// File: rtl/rsc_thr_reg.sv
module rsc_thr_reg
    import rsc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             allow_i,
    input  logic             wr_en_i,
    input  logic [THR_W-1:0] wr_data_i,
    output logic [THR_W-1:0] q_o
);
    always_ff @(posedge clk) begin
        if (rst)                     q_o <= '0;
        else if (allow_i && wr_en_i) q_o <= wr_data_i;
    end
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
    import rsc_pkg::*;
#(
    parameter int                PWRUP_CYCLES = 65536,
    parameter int                ADDR_W       = 16,
    parameter logic [ADDR_W-1:0] RESTART_ADDR = ADDR_W'(16'h8000)
) (
    input  logic              clk,
    input  logic              por_low_i,
    input  logic              bor_low_i,
    input  logic              wr_en_i,
    input  logic [THR_W-1:0]  wr_thr_i,
    output logic              rst_n_o,
    output logic              por_event_o,
    output logic              bor_event_o,
    output logic              reset_class_o,
    output logic [THR_W-1:0]  bor_thr_o,
    output logic [ADDR_W-1:0] restart_addr_o
);
    seq_st_e st, st_nxt;
    evt_t    evt_q, evt_nxt;
    rcls_e   cls_q;
    logic    bor_s;
    logic    dly_done;
    logic    dly_clr;

    rsc_sync #(.STAGES(2), .RST_VAL(1'b1)) u_bor_sync (
        .clk (clk),
        .rst (por_low_i),
        .d_i (bor_low_i),
        .q_o (bor_s)
    );

    assign dly_clr = por_low_i || bor_s || (st != ST_PWRUP);

    rsc_pwrup_timer #(.CYCLES(PWRUP_CYCLES)) u_timer (
        .clk    (clk),
        .clr_i  (dly_clr),
        .done_o (dly_done)
    );

    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_PWRUP:    if (!bor_s && dly_done) st_nxt = ST_RUN;
            ST_BOR_HOLD: if (!bor_s)             st_nxt = ST_RUN;
            ST_RUN:      if (bor_s)              st_nxt = ST_BOR_HOLD;
            default:                             st_nxt = ST_PWRUP;
        endcase
        evt_nxt = release_kind(st, st_nxt);
    end

    always_ff @(posedge clk) begin
        if (por_low_i) begin
            st    <= ST_PWRUP;
            evt_q <= '0;
            cls_q <= RCLS_POWERON;
        end else begin
            st    <= st_nxt;
            evt_q <= evt_nxt;
            if (is_running(st) && bor_s) cls_q <= RCLS_BROWNOUT;
        end
    end

    rsc_thr_reg u_thr (
        .clk       (clk),
        .rst       (por_low_i),
        .allow_i   (is_running(st)),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_thr_i),
        .q_o       (bor_thr_o)
    );

    assign rst_n_o        = is_running(st);
    assign por_event_o    = evt_q.por_evt;
    assign bor_event_o    = evt_q.bor_evt;
    assign reset_class_o  = cls_q;
    assign restart_addr_o = RESTART_ADDR;
endmodule

// File: rtl/rst_seq_ctrl_chk.sv
module rst_seq_ctrl_chk
    import rsc_pkg::*;
(
    input logic             clk,
    input logic             por_low_i,
    input logic             rst_n_o,
    input logic             por_event_o,
    input logic             bor_event_o,
    input logic             reset_class_o,
    input logic [THR_W-1:0] bor_thr_o
);
    // R11: the two release pulses never coincide
    a_r11_events_onehot: assert property (@(posedge clk) disable iff (por_low_i)
        $onehot0({por_event_o, bor_event_o}));

    // R2, R6: a pulse appears only in the cycle where reset is released
    a_r6_event_at_release: assert property (@(posedge clk) disable iff (por_low_i)
        (por_event_o || bor_event_o) |-> (rst_n_o && !$past(rst_n_o)));

    // R11: each rise of the reset output is announced by a pulse
    a_r11_rise_has_event: assert property (@(posedge clk) disable iff (por_low_i)
        $rose(rst_n_o) |-> (por_event_o || bor_event_o));

    // R9: the threshold field cannot be written while reset is held
    a_r9_frozen_in_reset: assert property (@(posedge clk) disable iff (por_low_i)
        !rst_n_o |=> $stable(bor_thr_o));

    // R4: a brownout release carries the brownout class
    a_r4_bor_class: assert property (@(posedge clk) disable iff (por_low_i)
        bor_event_o |-> (reset_class_o == RCLS_BROWNOUT));
endmodule

bind rst_seq_ctrl rst_seq_ctrl_chk u_chk (
    .clk           (clk),
    .por_low_i     (por_low_i),
    .rst_n_o       (rst_n_o),
    .por_event_o   (por_event_o),
    .bor_event_o   (bor_event_o),
    .reset_class_o (reset_class_o),
    .bor_thr_o     (bor_thr_o)
);

// File: tb/rst_seq_ctrl_bench.sv
module rst_seq_ctrl_bench;
    localparam int N = 20;

    logic        clk = 1'b0;
    logic        por_low_i = 1'b1;
    logic        bor_low_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [1:0]  wr_thr_i = 2'b00;
    logic        rst_n_o, por_event_o, bor_event_o, reset_class_o;
    logic [1:0]  bor_thr_o;
    logic [15:0] restart_addr_o;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    rst_seq_ctrl #(.PWRUP_CYCLES(N)) u_rst_seq_ctrl (
        .clk            (clk),
        .por_low_i      (por_low_i),
        .bor_low_i      (bor_low_i),
        .wr_en_i        (wr_en_i),
        .wr_thr_i       (wr_thr_i),
        .rst_n_o        (rst_n_o),
        .por_event_o    (por_event_o),
        .bor_event_o    (bor_event_o),
        .reset_class_o  (reset_class_o),
        .bor_thr_o      (bor_thr_o),
        .restart_addr_o (restart_addr_o)
    );

    // {wr_en, wr_data, expected field}; applied while running (R9)
    localparam logic [4:0] VEC [6] = '{
        {1'b1, 2'd2, 2'd2},
        {1'b0, 2'd3, 2'd2},
        {1'b1, 2'd1, 2'd1},
        {1'b1, 2'd0, 2'd0},
        {1'b1, 2'd3, 2'd3},
        {1'b0, 2'd0, 2'd3}
    };

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        step(3);
        // R1 and R10 while held in power-on reset
        check(rst_n_o == 1'b0, "R1 rst_n", rst_n_o, 0);
        check(bor_thr_o == 2'd0, "R1 thr", bor_thr_o, 0);
        check(reset_class_o == 1'b0, "R1 class", reset_class_o, 0);
        check({por_event_o, bor_event_o} == 2'b00, "R1 events",
              {por_event_o, bor_event_o}, 0);
        check(restart_addr_o == 16'h8000, "R10 addr", restart_addr_o, 16'h8000);

        // R2: power-on release latency and pulse
        por_low_i = 1'b0;
        step(N + 1);
        check(rst_n_o == 1'b0, "R2 still held", rst_n_o, 0);
        step(1);
        check(rst_n_o == 1'b1, "R2 released", rst_n_o, 1);
        check(por_event_o == 1'b1, "R2 por_event", por_event_o, 1);
        check(bor_event_o == 1'b0, "R11 no bor_event", bor_event_o, 0);
        step(1);
        check(por_event_o == 1'b0, "R2 pulse width", por_event_o, 0);

        // R9: table of writes while running
        for (int v = 0; v < 6; v++) begin
            wr_en_i  = VEC[v][4];
            wr_thr_i = VEC[v][3:2];
            step(1);
            check(bor_thr_o == VEC[v][1:0], "R9 write", bor_thr_o, VEC[v][1:0]);
        end
        wr_en_i = 1'b0;

        // R4: brownout entry
        bor_low_i = 1'b1;
        step(2);
        check(rst_n_o == 1'b1, "R4 not yet", rst_n_o, 1);
        step(1);
        check(rst_n_o == 1'b0, "R4 asserted", rst_n_o, 0);
        check(reset_class_o == 1'b1, "R4 class", reset_class_o, 1);

        // R9: write attempt during reset is ignored
        wr_en_i  = 1'b1;
        wr_thr_i = 2'd1;
        step(1);
        wr_en_i = 1'b0;
        check(bor_thr_o == 2'd3, "R9 ignored in reset", bor_thr_o, 3);

        // R5: held for a long brownout
        step(3 * N);
        check(rst_n_o == 1'b0, "R5 held", rst_n_o, 0);

        // R6, R7: brownout recovery with no delay
        bor_low_i = 1'b0;
        step(2);
        check(rst_n_o == 1'b0, "R6 not yet", rst_n_o, 0);
        step(1);
        check(rst_n_o == 1'b1, "R6 released", rst_n_o, 1);
        check(bor_event_o == 1'b1, "R6 bor_event", bor_event_o, 1);
        check(por_event_o == 1'b0, "R6 no por_event", por_event_o, 0);
        check(bor_thr_o == 2'd3, "R7 retained", bor_thr_o, 3);
        step(1);
        check(bor_event_o == 1'b0, "R6 pulse width", bor_event_o, 0);

        // R8: power-on clears the field
        por_low_i = 1'b1;
        step(2);
        check(bor_thr_o == 2'd0, "R8 cleared", bor_thr_o, 0);
        check(reset_class_o == 1'b0, "R1 class after por", reset_class_o, 0);
        check(rst_n_o == 1'b0, "R1 rst_n after por", rst_n_o, 0);

        // R3: brownout during power-up wait restarts the delay
        bor_low_i = 1'b1;
        por_low_i = 1'b0;
        step(N + 10);
        check(rst_n_o == 1'b0, "R3 held by brownout", rst_n_o, 0);
        bor_low_i = 1'b0;
        step(N + 1);
        check(rst_n_o == 1'b0, "R3 full delay", rst_n_o, 0);
        step(1);
        check(rst_n_o == 1'b1, "R3 released", rst_n_o, 1);
        check(por_event_o == 1'b1, "R3 por_event", por_event_o, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule